// File: doc/BRIEF.md
# Strobe-Committed Word Store

This block is a small register-file memory of eight 4-bit words with a 3-bit word address, a dedicated write-data input and a separate read-data output. Three control inputs govern it: a direction select `rw_sel` (low for write, high for read), a chip-select strobe `csel` and an output enable `oen`. A word is stored only at the moment the strobe is raised while the direction select is low. The address is then turned into a single active word-select line, and only the register of that word loads `wdata`.

The whole design runs on one system clock. The strobe is never used as a clock. A small state machine samples `csel` each cycle and produces a one-cycle commit pulse when it sees the strobe go high from its idle state in write mode. The states and transitions are:

- **ST_IDLE**: strobe low. On the strobe going high it moves to **ST_WR_HOLD** if `rw_sel` is low, issuing the commit pulse in that same cycle. It moves to **ST_RD_HOLD** if `rw_sel` is high.
- **ST_WR_HOLD** and **ST_RD_HOLD**: stay while the strobe is high, and return to **ST_IDLE** when it drops.

Reads are combinational. The addressed word appears on `rdata` only when `oen` and `rw_sel` are both high; otherwise the output reads zero, which stands in for a released bus.

Top module: `strobe_mem`

## Requirements
- R1: While `rst_n` is low, every word is cleared to zero; after reset every address reads 0.
- R2: When `csel` is sampled high at a clock edge from ST_IDLE with `rw_sel` = 0, `wdata` is stored in word `addr` at that edge. The stored value is readable from the next cycle.
- R3: A commit changes only the word whose index equals `addr`; at most one word-select line is active in any cycle.
- R4: Holding `csel` high after a commit causes no further stores, even if `wdata` or `addr` change while it stays high.
- R5: While `csel` is low, no word changes, whatever `addr`, `wdata` and `rw_sel` do.
- R6: Raising `csel` while `rw_sel` = 1 modifies no word.
- R7: `rdata` equals word `addr` when `oen` = 1 and `rw_sel` = 1, and is 0 whenever `oen` = 0 or `rw_sel` = 0.
- R8: A strobe that starts in read mode (ST_RD_HOLD) cannot become a write by lowering `rw_sel` while `csel` stays high. A store needs a fresh rise of `csel` from ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Data to store on commit |
| rw_sel | input | 1 | Direction select: 0 write, 1 read |
| csel | input | 1 | Chip-select strobe, commit on rise in write mode |
| oen | input | 1 | Output enable for reads |
| rdata | output | DATA_W | Read data, 0 when disabled |

## Verification
The bench builds the block with its default parameters: a 3-bit address and 4-bit words. At that size every one of the 16 data values can be committed to each of the 8 words, with all words read back after each store, so any stray store into a neighbouring word is caught. The small size also allows every address to be swept during the strobe-held, strobe-low, read-strobe and output-disable scenarios.

// File: rtl/strobe_mem_pkg.sv
package strobe_mem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_HOLD = 2'd1,
        ST_RD_HOLD = 2'd2
    } strobe_st_e;
endpackage

// File: rtl/strobe_fsm.sv
module strobe_fsm
    import strobe_mem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic csel,
    input  logic rw_sel,
    output logic commit
);
    strobe_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (csel) state_d = rw_sel ? ST_RD_HOLD : ST_WR_HOLD;
            ST_WR_HOLD: if (!csel) state_d = ST_IDLE;
            ST_RD_HOLD: if (!csel) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE:    commit = csel && !rw_sel;
            ST_WR_HOLD: commit = 1'b0;
            ST_RD_HOLD: commit = 1'b0;
            default:    commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/word_decode.sv
module word_decode #(
    parameter int ADDR_W = 3,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  sel
);
    always_comb begin
        sel = '0;
        if (en) sel[addr] = 1'b1;
    end
endmodule

// File: rtl/word_reg.sv
module word_reg #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/read_mux.sv
module read_mux #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH*DATA_W-1:0] words,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    rw_sel,
    input  logic                    oen,
    output logic [DATA_W-1:0]       rdata
);
    always_comb begin
        rdata = '0;
        if (oen && rw_sel) rdata = words[int'(addr)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/strobe_mem.sv
module strobe_mem #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rw_sel,
    input  logic              csel,
    input  logic              oen,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic                    commit;
    logic [DEPTH-1:0]        word_sel;
    logic [DEPTH*DATA_W-1:0] words;

    strobe_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .csel   (csel),
        .rw_sel (rw_sel),
        .commit (commit)
    );

    word_decode #(.ADDR_W(ADDR_W)) u_dec (
        .en   (commit),
        .addr (addr),
        .sel  (word_sel)
    );

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        word_reg #(.DATA_W(DATA_W)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (word_sel[w]),
            .d     (wdata),
            .q     (words[w*DATA_W +: DATA_W])
        );
    end

    read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .words  (words),
        .addr   (addr),
        .rw_sel (rw_sel),
        .oen    (oen),
        .rdata  (rdata)
    );
endmodule

// File: rtl/strobe_mem_chk.sv
module strobe_mem_chk #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csel,
    input logic              rw_sel,
    input logic              oen,
    input logic [DEPTH-1:0]  word_sel,
    input logic [DATA_W-1:0] rdata
);
    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_sel));

    // R2
    write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_sel != '0) |-> (csel && !rw_sel));

    // R5
    cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csel |-> (word_sel == '0));

    // R6
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csel && rw_sel) |-> (word_sel == '0));

    // R4
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_sel != '0) |=> (word_sel == '0));

    // R7
    out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(oen && rw_sel) |-> (rdata == '0));
endmodule

bind strobe_mem strobe_mem_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csel     (csel),
    .rw_sel   (rw_sel),
    .oen      (oen),
    .word_sel (word_sel),
    .rdata    (rdata)
);

// File: tb/sim_strobe_mem.sv
`timescale 1ns/1ps
module sim_strobe_mem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [3:0] wdata = '0;
    logic       rw_sel = 1'b1;
    logic       csel = 1'b0;
    logic       oen = 1'b0;
    logic [3:0] rdata;

    logic [3:0] model [8];
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    strobe_mem u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rw_sel(rw_sel), .csel(csel), .oen(oen), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            csel = 1'b0; rw_sel = 1'b1; oen = 1'b1; addr = 3'(a);
            #1 check(tag, rdata, model[a]);
        end
    endtask

    task automatic store(input int a, input logic [3:0] d);
        @(negedge clk);
        csel = 1'b0; oen = 1'b0; wdata = d; addr = 3'(a); rw_sel = 1'b0;
        @(negedge clk) csel = 1'b1;
        @(negedge clk) csel = 1'b0;
        model[a] = d;
    endtask

    initial begin
        #2ms;
        fails++;
        $display("FAIL watchdog: rdata=%0h expected=end of run", rdata);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: all words zero after reset
        read_all("R1 reset");

        // R2 R3: every value into every word, full readback each time
        for (int a = 0; a < 8; a++)
            for (int v = 0; v < 16; v++) begin
                store(a, 4'(v));
                read_all("R2/R3 sweep");
            end
        for (int a = 0; a < 8; a++) store(a, 4'(a + 3));
        read_all("R3 distinct");

        // R4: strobe held high, data and address change
        @(negedge clk);
        oen = 1'b0; csel = 1'b0; addr = 3'd5; wdata = 4'h9; rw_sel = 1'b0;
        @(negedge clk) csel = 1'b1;
        @(negedge clk) wdata = 4'h6;
        @(negedge clk) addr = 3'd2;
        @(negedge clk);
        @(negedge clk) csel = 1'b0;
        model[5] = 4'h9;
        read_all("R4 held strobe");

        // R5: strobe low, write mode, inputs wander
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            csel = 1'b0; rw_sel = 1'b0; addr = 3'(i); wdata = 4'(15 - i);
        end
        read_all("R5 strobe low");

        // R6: strobe raised in read mode
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            csel = 1'b0; rw_sel = 1'b1; addr = 3'(a); wdata = ~model[a];
            @(negedge clk) csel = 1'b1;
            @(negedge clk) csel = 1'b0;
        end
        read_all("R6 read strobe");

        // R8: read strobe turned to write mode while held
        @(negedge clk);
        csel = 1'b0; rw_sel = 1'b1; addr = 3'd4; wdata = 4'hA;
        @(negedge clk) csel = 1'b1;
        @(negedge clk) rw_sel = 1'b0;
        @(negedge clk);
        @(negedge clk) csel = 1'b0;
        read_all("R8 no late write");
        @(negedge clk);
        csel = 1'b0; rw_sel = 1'b0; addr = 3'd4; wdata = 4'hA;
        @(negedge clk) csel = 1'b1;
        @(negedge clk) csel = 1'b0;
        model[4] = 4'hA;
        read_all("R8 fresh strobe");

        // R7: output disabled by oen low or by write mode
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            csel = 1'b0; rw_sel = 1'b1; oen = 1'b0; addr = 3'(a);
            #1 check("R7 oen low", rdata, 4'h0);
            @(negedge clk);
            rw_sel = 1'b0; oen = 1'b1;
            #1 check("R7 write mode", rdata, 4'h0);
        end
        read_all("R7 enabled");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule